// File: doc/BRIEF.md
# Memory-Mapped Seconds Real-Time Clock

This peripheral keeps wall-clock time as a 32-bit count of seconds and exposes it through an APB-style register window of 4 KB. A parameterised prescaler divides the system clock down to one tick per second, and a free-running seconds counter advances on each tick. Software never loads that counter. Writing a time value stores the difference between the value written and the counter. Reading the time register adds the difference back to the live counter, so the time software sees moves in step with the counter from the moment it was set.

A plain match register, a shadow of the last value loaded, and a control register that always reads as enabled complete the time function. The interrupt registers exist only so that software finds them: they read zero and ignore writes, so the interrupt stays masked. Eight identification bytes sit in the last 32 bytes of the window. A separate one-cycle `match_pulse` output marks the moment the visible time starts to equal the match value. It is for observation only and drives no interrupt.

Bus accesses pass through a small phase tracker with the states IDLE, SETUP and ACCESS. IDLE goes to SETUP when `psel` rises with `penable` low. SETUP goes to ACCESS when `penable` follows, and that cycle is the one in which the access completes. SETUP goes back to IDLE if `psel` drops. ACCESS goes to SETUP when a new transfer starts right away, and to IDLE otherwise.

Top module: `apb_seconds_rtc`

## Requirements
- R1: After reset, time (offset 0x000), match (0x004) and load shadow (0x008) read 0 plus the number of whole seconds elapsed since reset, 0 and 0 respectively.
- R2: The seconds counter advances by exactly one every TICKS_PER_SEC clock cycles and wraps from 0xFFFFFFFF to 0.
- R3: A write of V to offset 0x008 makes the time register read V plus the seconds counted since that write, modulo 2^32. Offset 0x008 then reads V back.
- R4: Offset 0x004 is a 32-bit read/write register.
- R5: Offset 0x00C always reads 1, and writes to it have no effect.
- R6: Offsets 0x010, 0x014 and 0x018 always read 0. Writes to 0x010 and 0x01C have no effect.
- R7: Offsets 0xFE0 to 0xFFC, in 4-byte steps, return in bits [7:0] the bytes 0x31, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order. Bits [31:8] read 0.
- R8: Reads of any other offset, including unaligned ones, return 0. Writes to them change no register.
- R9: `match_pulse` is high for exactly one cycle, one cycle after the time value becomes equal to the match value. Equality that holds from reset produces no pulse.
- R10: `pready` is high in the first access cycle of every transfer. A setup phase with no access phase writes nothing.
- R11: With no load write, the time value changes by at most +1 from one cycle to the next. A read therefore returns either the old value or the new one, never a mix of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset inside the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while pready is high |
| pready | output | 1 | Transfer completes in this cycle |
| match_pulse | output | 1 | One-cycle pulse when time starts to equal match |

## Verification
The hardest case to reach from the ports is a time value that crosses 0xFFFFFFFF. A real second counter would need decades to get there. The bench loads 0xFFFFFFFE and then reads the time register back to back, while the prescaler is built with a divisor of 4. This runs the wrap, and every read that lands on a tick edge, within a few dozen cycles. Each expected value comes from the bench's own cycle count, divided by the divisor, plus the difference it derives from the value written.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_SETUP,
        AP_ACCESS
    } apb_phase_e;

    localparam logic [ADDR_W-1:0] OFF_TIME  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MATCH = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_IRAW  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_IMSK  = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_ICLR  = 12'h01C;

    // identification bytes, indexed by word within 0xFE0..0xFFC
    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_apb_fsm.sv
module rtc_apb_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_stb,
    output logic pready
);

    apb_phase_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AP_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AP_IDLE: begin
                if (psel && !penable) state_d = AP_SETUP;
            end
            AP_SETUP: begin
                if (!psel)        state_d = AP_IDLE;
                else if (penable) state_d = AP_ACCESS;
            end
            AP_ACCESS: begin
                if (psel && !penable) state_d = AP_SETUP;
                else                  state_d = AP_IDLE;
            end
            default: state_d = AP_IDLE;
        endcase
    end

    // outputs: the access completes in the cycle after a setup phase
    always_comb begin
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        pready = 1'b0;
        unique case (state_q)
            AP_SETUP: begin
                if (psel && penable) begin
                    pready = 1'b1;
                    wr_stb = pwrite;
                    rd_stb = !pwrite;
                end
            end
            AP_IDLE, AP_ACCESS: ;
            default: ;
        endcase
    end

    // R10: completion only during a selected access phase
    p_ready_in_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> (psel && penable));

    // R10: one completion per transfer, no back-to-back ready
    p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R2: the divider never passes its last count
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: a tick restarts the period
    p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [WIDTH-1:0] seconds
);

    always_ff @(posedge clk) begin
        if (!rst_n)    seconds <= '0;
        else if (tick) seconds <= seconds + 1'b1;
    end

    // R2: holds between ticks
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(seconds));

    // R2: one step per tick, wrapping at the top
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (seconds == $past(seconds) + 1'b1));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] seconds,
    output logic [DATA_W-1:0] rdata,
    output logic              match_pulse
);

    logic [DATA_W-1:0] delta_q;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] time_now;
    logic [DATA_W-1:0] rd_mux;
    logic              load_wr;
    logic              is_ident;
    logic              eq_now;
    logic              eq_q;

    assign time_now = delta_q + seconds;
    assign load_wr  = wr_stb && (addr == OFF_LOAD);
    assign is_ident = (addr[ADDR_W-1:5] == '1) && (addr[1:0] == 2'b00);
    assign eq_now   = (time_now == match_q);

    // writable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta_q <= '0;
            match_q <= '0;
            load_q  <= '0;
        end else if (wr_stb) begin
            unique case (addr)
                OFF_MATCH: match_q <= wdata;
                OFF_LOAD: begin
                    load_q  <= wdata;
                    delta_q <= wdata - seconds;
                end
                default: ;
            endcase
        end
    end

    // read decode
    always_comb begin
        rd_mux = '0;
        unique case (addr)
            OFF_TIME:  rd_mux = time_now;
            OFF_MATCH: rd_mux = match_q;
            OFF_LOAD:  rd_mux = load_q;
            OFF_CTRL:  rd_mux = DATA_W'(1);
            OFF_IMASK, OFF_IRAW, OFF_IMSK: rd_mux = '0;
            default: begin
                if (is_ident) rd_mux = DATA_W'(ident_byte(addr[4:2]));
            end
        endcase
    end

    assign rdata = rd_stb ? rd_mux : '0;

    // match edge detector; equality present at reset does not pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q        <= 1'b1;
            match_pulse <= 1'b0;
        end else begin
            eq_q        <= eq_now;
            match_pulse <= eq_now && !eq_q;
        end
    end

    // R3: load shadow captures the written value
    p_load_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (load_q == $past(wdata)));

    // R3: right after a load the time equals the value, or one more on a tick
    p_load_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> ((time_now - $past(wdata)) <= DATA_W'(1)));

    // R11: without a load the time only holds or steps by one
    p_time_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_wr |=> (time_now == $past(time_now) || time_now == $past(time_now) + 1'b1));

    // R9: the pulse lasts a single cycle
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    // R4: match changes only through a write to its offset
    p_match_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && addr == OFF_MATCH) |=> $stable(match_q));

endmodule

// File: rtl/apb_seconds_rtc.sv
module apb_seconds_rtc
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              match_pulse
);

    logic              wr_stb;
    logic              rd_stb;
    logic              tick;
    logic [DATA_W-1:0] seconds;

    rtc_apb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .pready  (pready)
    );

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_sec_counter #(.WIDTH(DATA_W)) u_secs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .seconds (seconds)
    );

    rtc_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .rd_stb      (rd_stb),
        .addr        (paddr),
        .wdata       (pwdata),
        .seconds     (seconds),
        .rdata       (prdata),
        .match_pulse (match_pulse)
    );

    // R10: a write strobe only ever comes from a completing transfer
    p_write_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (pready && pwrite));

endmodule

// File: tb/tb_apb_seconds_rtc.sv
`timescale 1ns/1ps
module tb_apb_seconds_rtc;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        match_pulse;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    int unsigned n_pulse = 0;
    int unsigned n_double = 0;
    logic        pulse_prev = 1'b0;
    logic [31:0] mdelta = '0;
    logic        done = 1'b0;

    apb_seconds_rtc #(.TICKS_PER_SEC(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .match_pulse(match_pulse)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (match_pulse) n_pulse <= n_pulse + 1;
            if (match_pulse && pulse_prev) n_double <= n_double + 1;
            pulse_prev <= match_pulse;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, output int unsigned acc);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        acc = cyc;
        check("R10 pready on write", {31'd0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d, output int unsigned acc);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        acc = cyc;
        check("R10 pready on read", {31'd0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        int unsigned c;
        apb_rd(a, d, c);
        check(req, d, exp);
    endtask

    task automatic time_chk(input string req);
        logic [31:0] d;
        int unsigned c;
        apb_rd(12'h000, d, c);
        check(req, d, mdelta + 32'(c / DIV));
    endtask

    task automatic load_time(input logic [31:0] v);
        int unsigned c;
        apb_wr(12'h008, v, c);
        mdelta = v - 32'(c / DIV);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        int unsigned c;
        logic [31:0] d;
        logic [31:0] target;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        time_chk("R1 time after reset");
        rd_chk("R1 match after reset", 12'h004, 32'd0);
        rd_chk("R1 load after reset", 12'h008, 32'd0);

        // R2: time follows elapsed seconds over several periods
        for (int i = 0; i < 12; i++) time_chk("R2 seconds advance");

        // R3 and R2 wrap: load near the top and sweep reads across the wrap
        load_time(32'hFFFF_FFFE);
        rd_chk("R3 load shadow", 12'h008, 32'hFFFF_FFFE);
        for (int i = 0; i < 16; i++) time_chk("R2 R3 wrap sweep");
        load_time(32'h1234_5678);
        for (int i = 0; i < 6; i++) time_chk("R3 loaded time");
        rd_chk("R3 load shadow second value", 12'h008, 32'h1234_5678);

        // R11: back-to-back reads never step backward or by more than one
        begin
            logic [31:0] prev;
            apb_rd(12'h000, prev, c);
            for (int i = 0; i < 10; i++) begin
                apb_rd(12'h000, d, c);
                check("R11 coherent step", {31'd0, (d - prev) <= 32'd1}, 32'd1);
                prev = d;
            end
        end

        // R4: match register patterns
        foreach (target[k]) begin
            apb_wr(12'h004, 32'd1 << k, c);
            rd_chk("R4 match walking one", 12'h004, 32'd1 << k);
        end
        apb_wr(12'h004, 32'hA5A5_5A5A, c);
        rd_chk("R4 match pattern", 12'h004, 32'hA5A5_5A5A);

        // R5: control
        rd_chk("R5 control reads 1", 12'h00C, 32'd1);
        apb_wr(12'h00C, 32'd0, c);
        rd_chk("R5 control after write 0", 12'h00C, 32'd1);
        apb_wr(12'h00C, 32'hFFFF_FFFF, c);
        rd_chk("R5 control after write ones", 12'h00C, 32'd1);
        time_chk("R5 time unaffected");

        // R6: interrupt registers
        apb_wr(12'h010, 32'd1, c);
        apb_wr(12'h01C, 32'hFFFF_FFFF, c);
        rd_chk("R6 mask reads 0", 12'h010, 32'd0);
        rd_chk("R6 raw reads 0", 12'h014, 32'd0);
        rd_chk("R6 masked reads 0", 12'h018, 32'd0);
        rd_chk("R6 clear reads 0", 12'h01C, 32'd0);

        // R7: identification bytes
        begin
            logic [7:0] ids [8];
            ids = '{8'h31, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int i = 0; i < 8; i++)
                rd_chk("R7 ident byte", 12'hFE0 + 12'(4 * i), {24'd0, ids[i]});
        end

        // R8: sweep of every unlisted aligned word, plus unaligned probes
        for (int w = 8; w < 1016; w++) rd_chk("R8 unlisted reads 0", 12'(4 * w), 32'd0);
        rd_chk("R8 unaligned 0x001", 12'h001, 32'd0);
        rd_chk("R8 unaligned 0x006", 12'h006, 32'd0);
        rd_chk("R8 unaligned 0xFE1", 12'hFE1, 32'd0);
        rd_chk("R8 unaligned 0xFFE", 12'hFFE, 32'd0);
        apb_wr(12'h004, 32'h0BAD_F00D, c);
        apb_wr(12'h020, 32'hFFFF_FFFF, c);
        apb_wr(12'hFDC, 32'hFFFF_FFFF, c);
        apb_wr(12'h005, 32'hFFFF_FFFF, c);
        apb_wr(12'h009, 32'hFFFF_FFFF, c);
        apb_wr(12'hFE0, 32'hFFFF_FFFF, c);
        rd_chk("R8 match untouched", 12'h004, 32'h0BAD_F00D);
        rd_chk("R8 load untouched", 12'h008, 32'h1234_5678);
        rd_chk("R8 ident untouched", 12'hFE0, 32'h31);
        time_chk("R8 time untouched");

        // R10: setup phase with no access writes nothing
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h004; pwdata = 32'h7777_7777; penable = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 no ready in setup", {31'd0, pready}, 32'd0);
        psel = 1'b0; pwrite = 1'b0;
        rd_chk("R10 setup-only no write", 12'h004, 32'h0BAD_F00D);

        // R9: match a time two seconds ahead, expect one single-cycle pulse
        apb_rd(12'h000, d, c);
        target = mdelta + 32'(c / DIV) + 32'd2;
        apb_wr(12'h004, target, c);
        n_pulse = 0;
        n_double = 0;
        repeat (4 * DIV + 4) @(negedge clk);
        check("R9 one pulse at match", n_pulse, 32'd1);
        check("R9 pulse width", n_double, 32'd0);

        // R9: far-away match gives no pulse
        apb_wr(12'h004, mdelta + 32'(cyc / DIV) + 32'd1000, c);
        n_pulse = 0;
        repeat (4 * DIV) @(negedge clk);
        check("R9 no pulse when not equal", n_pulse, 32'd0);

        // R9 with R3: loading the match value starts equality
        apb_wr(12'h004, 32'h0000_0500, c);
        n_pulse = 0;
        load_time(32'h0000_0500);
        repeat (2) @(negedge clk);
        check("R9 pulse on load to match", n_pulse, 32'd1);

        done = 1'b1;
        finish_run();
    end

endmodule